// File: doc/BRIEF.md
# Converter-Style Serial Register Port

This block is the serial slave side of an emulated sigma-delta converter. A host drives a serial clock, a data-in line and an optional active-low chip select. The block answers on one output line that carries read data during a read and a conversion-ready flag at all other times. Each transaction opens with an 8-bit command byte. The byte names a target register and a direction, and the data phase that follows is as long as that register is wide.

The serial pins are treated as asynchronous. They are brought into the system clock domain by a small synchronizer, and the serial clock edges are found there. A long run of ones on the data-in line returns the whole port to its power-on state. The emulated modulator delivers each finished conversion through a one-cycle strobe together with a data word and a channel number. It reads the live mode word from a port.

Top module: `adcspi_slave`

## Requirements
- R1: After `rst_n` is released, the mode word equals `MODE_RST` (default 0x080060) and, with chip select low and no conversion delivered, `dout_rdy` is high.
- R2: In the command byte, bit 6 is 1 for a read and 0 for a write, and bits 5:3 hold the register address (0 = status, 1 = mode, 3 = data). 0x08 writes the 24-bit mode register and 0x48 reads it back MSB first. The new mode value appears on `mode_word` once the 24th data bit is in.
- R3: A `conv_valid` strobe stores `conv_data` and `conv_chan`. It drives `dout_rdy` low while chip select is low and no transfer is shifting out data.
- R4: Command 0x58 reads the 24-bit conversion word MSB first, and `dout_rdy` returns high after its last bit. A second read before the next conversion returns the same word.
- R5: With mode bit 20 set, a data read is 32 bits long: the conversion word followed by the status byte. The status byte (also read alone with 0x40) holds the inverted ready flag in bit 7, zeros in bits 6:4 and the channel in bits 3:0.
- R6: When 40 or more consecutive rising serial-clock edges sample a 1 on data-in with chip select low, every register returns to its power-on value and `dout_rdy` goes high. The next 8 bits are taken as a command byte, whether the run had 40 or more ones.
- R7: A run of 39 ones followed by a zero does not reset the port, so the mode register keeps its value.
- R8: Chip select rising in the middle of a transaction returns the port to the command phase, and a partly shifted write changes no register.
- R9: With chip select tied low for the whole run, every transaction and the run-of-ones reset work using only the serial clock, data-in and `dout_rdy`.
- R10: Data-in is sampled on the serial clock's rising edge and read data advances on its falling edge. The MSB of a read is on `dout_rdy` once the last command bit has been taken, before any falling edge. `dout_rdy` is high while chip select is high.
- R11: A conversion that arrives during a data read does not disturb the word being shifted out. `dout_rdy` stays low after that read, and the next read returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| din | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select, may be tied low |
| conv_valid | input | 1 | One-cycle strobe when a conversion is complete |
| conv_data | input | DATA_W | Conversion result |
| conv_chan | input | 4 | Channel of the conversion result |
| dout_rdy | output | 1 | Serial read data, otherwise the active-low ready flag |
| mode_word | output | MODE_W | Current mode register contents |

## Verification
A pin change passes two synchronizer flops and one edge-detect flop. The register it affects therefore updates on the third rising `clk` edge after the change, and `dout_rdy` follows in the same cycle. A `conv_valid` strobe shows on `dout_rdy` one edge after it is sampled. The bench holds every serial-clock level for 8 system clocks and drives inputs and samples `dout_rdy` on falling `clk` edges. Each read bit is therefore sampled 8 clocks after the falling edge that produced it and just before the rising edge where the host would take it, which is well after its 3-cycle latency.

// File: rtl/adcspi_pkg.sv
// Package: shared constants and types for the converter-style serial port.
// Assumes an 8-bit command byte and an 8-bit status byte carrying a 4-bit channel.
package adcspi_pkg;
    localparam int CMD_W    = 8;
    localparam int STAT_W   = 8;
    localparam int CHAN_W   = 4;
    localparam int RNW_BIT  = 6;
    localparam int ADDR_LSB = 3;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd3;

    typedef enum logic {
        PH_CMD = 1'b0,
        PH_DAT = 1'b1
    } phase_t;
endpackage

// File: rtl/adcspi_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes every bit is an independent level; IDLE is the value held in reset.
module adcspi_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/adcspi_run_det.sv
// Module: counts consecutive ones sampled on data-in at serial rising edges.
// Assumes inputs are already synchronized; hit is asserted on the edge that
// completes a run of RUN_LEN ones and on every further one of the same run.
module adcspi_run_det #(
    parameter int RUN_LEN = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_rise,
    input  logic s_din,
    input  logic s_cs_n,
    output logic hit
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_q;

    // Saturating run counter, cleared by a zero or a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (s_cs_n) begin
            run_q <= '0;
        end else if (s_rise) begin
            if (!s_din)                         run_q <= '0;
            else if (run_q != CW'(RUN_LEN))     run_q <= run_q + 1'b1;
        end
    end

    assign hit = s_rise && !s_cs_n && s_din && (run_q >= CW'(RUN_LEN - 1));
endmodule

// File: rtl/adcspi_engine.sv
// Module: command/data phase sequencer and register file of the serial port.
// Assumes synchronized inputs with one-cycle edge pulses; MODE_W >= 8.
module adcspi_engine
    import adcspi_pkg::*;
#(
    parameter int                DATA_W   = 24,
    parameter int                MODE_W   = 24,
    parameter logic [MODE_W-1:0] MODE_RST = '0,
    parameter int                DSTA_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_rise,
    input  logic              s_fall,
    input  logic              s_din,
    input  logic              s_cs_n,
    input  logic              soft_rst,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CHAN_W-1:0] conv_chan,
    output logic [MODE_W-1:0] mode_word,
    output logic              reading,
    output logic              out_bit,
    output logic              rdy_n,
    output logic              at_cmd_start
);
    localparam int SR_W  = (DATA_W + STAT_W > MODE_W) ? DATA_W + STAT_W : MODE_W;
    localparam int LEN_W = $clog2(SR_W + 1);

    phase_t              phase_q;
    logic [LEN_W-1:0]    cnt_q, len_q, load_len;
    logic [MODE_W-2:0]   in_sr;
    logic [MODE_W-1:0]   next_sr;
    logic [SR_W-1:0]     out_sr, load_val;
    logic                rnw_q, rdy_q, conv_seen_q;
    logic [ADDR_W-1:0]   addr_q, cmd_addr;
    logic                cmd_rnw;
    logic [MODE_W-1:0]   mode_q;
    logic [DATA_W-1:0]   data_q;
    logic [CHAN_W-1:0]   chan_q;
    logic [STAT_W-1:0]   status;

    assign next_sr  = {in_sr, s_din};
    assign cmd_rnw  = next_sr[RNW_BIT];
    assign cmd_addr = next_sr[ADDR_LSB +: ADDR_W];
    assign status   = {rdy_q, {(STAT_W-CHAN_W-1){1'b0}}, chan_q};

    // Pick the length and the MSB-aligned read image of the addressed register.
    always_comb begin
        load_len = LEN_W'(CMD_W);
        load_val = '0;
        case (cmd_addr)
            ADDR_STAT: begin
                load_len = LEN_W'(STAT_W);
                load_val = SR_W'(status) << (SR_W - STAT_W);
            end
            ADDR_MODE: begin
                load_len = LEN_W'(MODE_W);
                load_val = SR_W'(mode_q) << (SR_W - MODE_W);
            end
            ADDR_DATA: begin
                if (cmd_rnw && mode_q[DSTA_BIT]) begin
                    load_len = LEN_W'(DATA_W + STAT_W);
                    load_val = SR_W'({data_q, status}) << (SR_W - DATA_W - STAT_W);
                end else begin
                    load_len = LEN_W'(DATA_W);
                    load_val = SR_W'(data_q) << (SR_W - DATA_W);
                end
            end
            default: ;
        endcase
    end

    // Phase sequencing, register updates and conversion capture.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            phase_q     <= PH_CMD;
            cnt_q       <= '0;
            len_q       <= '0;
            in_sr       <= '0;
            out_sr      <= '0;
            rnw_q       <= 1'b0;
            addr_q      <= '0;
            mode_q      <= MODE_RST;
            data_q      <= '0;
            chan_q      <= '0;
            rdy_q       <= 1'b1;
            conv_seen_q <= 1'b0;
        end else begin
            if (s_cs_n) begin
                phase_q <= PH_CMD;
                cnt_q   <= '0;
            end else if (s_rise) begin
                in_sr <= next_sr[MODE_W-2:0];
                if (phase_q == PH_CMD) begin
                    if (cnt_q == LEN_W'(CMD_W - 1)) begin
                        phase_q <= PH_DAT;
                        cnt_q   <= '0;
                        rnw_q   <= cmd_rnw;
                        addr_q  <= cmd_addr;
                        len_q   <= load_len;
                        out_sr  <= load_val;
                        if (cmd_rnw && cmd_addr == ADDR_DATA) conv_seen_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else if (cnt_q == len_q - LEN_W'(1)) begin
                    phase_q <= PH_CMD;
                    cnt_q   <= '0;
                    if (!rnw_q && addr_q == ADDR_MODE) mode_q <= next_sr;
                    if (rnw_q && addr_q == ADDR_DATA && !conv_seen_q) rdy_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (s_fall && reading && cnt_q != '0) begin
                out_sr <= out_sr << 1;
            end
            if (conv_valid) begin
                data_q      <= conv_data;
                chan_q      <= conv_chan;
                rdy_q       <= 1'b0;
                conv_seen_q <= 1'b1;
            end
        end
    end

    assign reading      = (phase_q == PH_DAT) && rnw_q;
    assign out_bit      = out_sr[SR_W-1];
    assign rdy_n        = rdy_q;
    assign mode_word    = mode_q;
    assign at_cmd_start = (phase_q == PH_CMD) && (cnt_q == '0);
endmodule

// File: rtl/adcspi_slave.sv
// Module: top of the converter-style serial port; synchronizes the pins,
// finds serial clock edges and muxes read data or ready onto the output.
// Assumes sclk is slower than clk by at least 4x per level.
module adcspi_slave
    import adcspi_pkg::*;
#(
    parameter int                DATA_W      = 24,
    parameter int                MODE_W      = 24,
    parameter logic [MODE_W-1:0] MODE_RST    = 24'h080060,
    parameter int                DSTA_BIT    = 20,
    parameter int                RUN_LEN     = 40,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              cs_n,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CHAN_W-1:0] conv_chan,
    output logic              dout_rdy,
    output logic [MODE_W-1:0] mode_word
);
    logic [2:0] pins_s;
    logic       s_cs_n, s_sclk, s_din, sclk_d, s_rise, s_fall;
    logic       hit, reading, out_bit, rdy_n, at_cmd_start;

    adcspi_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b110)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({cs_n, sclk, din}),
        .q   (pins_s)
    );

    assign s_cs_n = pins_s[2];
    assign s_sclk = pins_s[1];
    assign s_din  = pins_s[0];

    // Delay the synchronized serial clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= s_sclk;
    end

    assign s_rise = s_sclk & ~sclk_d;
    assign s_fall = ~s_sclk & sclk_d;

    adcspi_run_det #(.RUN_LEN(RUN_LEN)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_rise (s_rise),
        .s_din  (s_din),
        .s_cs_n (s_cs_n),
        .hit    (hit)
    );

    adcspi_engine #(
        .DATA_W   (DATA_W),
        .MODE_W   (MODE_W),
        .MODE_RST (MODE_RST),
        .DSTA_BIT (DSTA_BIT)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_rise       (s_rise),
        .s_fall       (s_fall),
        .s_din        (s_din),
        .s_cs_n       (s_cs_n),
        .soft_rst     (hit),
        .conv_valid   (conv_valid),
        .conv_data    (conv_data),
        .conv_chan    (conv_chan),
        .mode_word    (mode_word),
        .reading      (reading),
        .out_bit      (out_bit),
        .rdy_n        (rdy_n),
        .at_cmd_start (at_cmd_start)
    );

    assign dout_rdy = s_cs_n ? 1'b1 : (reading ? out_bit : rdy_n);
endmodule

// File: rtl/adcspi_slave_chk.sv
// Module: temporal checks on the serial port, bound into adcspi_slave.
// Assumes the internal edge, reset-hit and ready signals of the top.
module adcspi_slave_chk #(
    parameter int                MODE_W   = 24,
    parameter logic [MODE_W-1:0] MODE_RST = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_rise,
    input logic              s_cs_n,
    input logic              hit,
    input logic              conv_valid,
    input logic              rdy_n,
    input logic              at_cmd_start,
    input logic [MODE_W-1:0] mode_word
);
    a_r6_run_restores_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (mode_word == MODE_RST) && rdy_n && at_cmd_start);

    a_r8_deselect_to_command: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |=> at_cmd_start);

    a_r3_conversion_flags_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !hit) |=> !rdy_n);

    a_r4_ready_clears_on_serial_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $past(s_rise));

    a_r2_mode_moves_on_serial_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !s_rise |=> $stable(mode_word));
endmodule

bind adcspi_slave adcspi_slave_chk #(.MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_rise       (s_rise),
    .s_cs_n       (s_cs_n),
    .hit          (hit),
    .conv_valid   (conv_valid),
    .rdy_n        (rdy_n),
    .at_cmd_start (at_cmd_start),
    .mode_word    (mode_word)
);

// File: tb/adcspi_slave_bench.sv
// Directed bench for adcspi_slave: one task per scenario, each checking itself.
module adcspi_slave_bench;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic        cs_n = 1'b1;
    logic        conv_valid = 1'b0;
    logic [23:0] conv_data = '0;
    logic [3:0]  conv_chan = '0;
    logic        dout_rdy;
    logic [23:0] mode_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adcspi_slave u_adcspi_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .din        (din),
        .cs_n       (cs_n),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .conv_chan  (conv_chan),
        .dout_rdy   (dout_rdy),
        .mode_word  (mode_word)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_bits(input int n, input logic [31:0] tx, output logic [31:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0;
            din  = tx[i];
            wait_clks(HALF);
            rx[i] = dout_rdy;
            sclk = 1'b1;
            wait_clks(HALF);
        end
        din = 1'b0;
    endtask

    task automatic deliver(input logic [23:0] d, input logic [3:0] ch);
        conv_data  = d;
        conv_chan  = ch;
        conv_valid = 1'b1;
        wait_clks(1);
        conv_valid = 1'b0;
        wait_clks(3);
    endtask

    task automatic read_reg(input logic [7:0] cmd, input int n, output logic [31:0] rx);
        logic [31:0] junk;
        spi_bits(8, {24'h0, cmd}, junk);
        spi_bits(n, 32'h0, rx);
    endtask

    task automatic write_mode(input logic [23:0] v);
        logic [31:0] junk;
        spi_bits(8, 32'h08, junk);
        spi_bits(24, {8'h0, v}, junk);
    endtask

    task automatic reselect();
        cs_n = 1'b1;
        wait_clks(HALF);
        cs_n = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic t_reset_state();
        logic [31:0] rx;
        check("R10 dout high while deselected", {31'h0, dout_rdy}, 32'h1);
        cs_n = 1'b0;
        wait_clks(HALF);
        check("R1 ready idle high", {31'h0, dout_rdy}, 32'h1);
        check("R1 mode port default", {8'h0, mode_word}, 32'h080060);
        read_reg(8'h48, 24, rx);
        check("R1 mode readback default", rx, 32'h080060);
    endtask

    task automatic t_mode_write();
        logic [31:0] rx;
        write_mode(24'h0A55A5);
        check("R2 mode port after write", {8'h0, mode_word}, 32'h0A55A5);
        read_reg(8'h48, 24, rx);
        check("R2 mode readback", rx, 32'h0A55A5);
    endtask

    task automatic t_data_read();
        logic [31:0] rx, junk;
        deliver(24'hC3A51E, 4'h5);
        check("R3 ready low after conversion", {31'h0, dout_rdy}, 32'h0);
        spi_bits(8, 32'h58, junk);
        check("R10 MSB before first falling edge", {31'h0, dout_rdy}, 32'h1);
        spi_bits(24, 32'h0, rx);
        check("R4 data word", rx, 32'hC3A51E);
        check("R4 ready high after read", {31'h0, dout_rdy}, 32'h1);
        read_reg(8'h58, 24, rx);
        check("R4 repeated read same word", rx, 32'hC3A51E);
        read_reg(8'h40, 8, rx);
        check("R5 status byte alone", rx, 32'h85);
    endtask

    task automatic t_conv_during_read();
        logic [31:0] rxa, rxb, junk;
        deliver(24'h111111, 4'h1);
        spi_bits(8, 32'h58, junk);
        spi_bits(12, 32'h0, rxa);
        deliver(24'h222222, 4'h2);
        spi_bits(12, 32'h0, rxb);
        check("R11 word intact across conversion", {8'h0, rxa[11:0], rxb[11:0]}, 32'h111111);
        check("R11 ready stays low", {31'h0, dout_rdy}, 32'h0);
        read_reg(8'h58, 24, rxa);
        check("R11 next read new word", rxa, 32'h222222);
    endtask

    task automatic t_status_append();
        logic [31:0] rx;
        write_mode(24'h1A55A5);
        deliver(24'h00F00D, 4'hA);
        read_reg(8'h58, 32, rx);
        check("R5 word plus status", rx, 32'h00F00D0A);
    endtask

    task automatic t_short_run();
        logic [31:0] rx;
        spi_bits(32, 32'hFFFFFFFF, rx);
        spi_bits(8, 32'hFE, rx);
        reselect();
        read_reg(8'h48, 24, rx);
        check("R7 39 ones keep mode", rx, 32'h1A55A5);
    endtask

    task automatic t_cs_abort();
        logic [31:0] rx;
        spi_bits(8, 32'h08, rx);
        spi_bits(12, 32'h000FFF, rx);
        reselect();
        check("R8 mode unchanged after abort", {8'h0, mode_word}, 32'h1A55A5);
        read_reg(8'h48, 24, rx);
        check("R8 command phase after abort", rx, 32'h1A55A5);
    endtask

    task automatic t_run_reset();
        logic [31:0] rx;
        deliver(24'hABCDEF, 4'h3);
        check("R3 ready low before run", {31'h0, dout_rdy}, 32'h0);
        spi_bits(32, 32'hFFFFFFFF, rx);
        spi_bits(8, 32'hFF, rx);
        check("R6 ready high after 40 ones", {31'h0, dout_rdy}, 32'h1);
        check("R6 mode port default", {8'h0, mode_word}, 32'h080060);
        read_reg(8'h48, 24, rx);
        check("R9 three-wire command after run", rx, 32'h080060);
        read_reg(8'h40, 8, rx);
        check("R6 status cleared", rx, 32'h80);
        write_mode(24'h0A55A5);
        spi_bits(32, 32'hFFFFFFFF, rx);
        spi_bits(13, 32'h1FFF, rx);
        read_reg(8'h48, 24, rx);
        check("R6 45 ones reset and command phase", rx, 32'h080060);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        t_reset_state();
        t_mode_write();
        t_data_read();
        t_conv_during_read();
        t_status_append();
        t_short_run();
        t_cs_abort();
        t_run_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule